// File: doc/BRIEF.md
# I2C Byte-Level Bus Master

This block is a register-programmed I2C bus master that moves a single byte per software command. Software issues start, stop and resume commands through a write-only command register, and it sends a byte by writing the data register. It receives a byte by issuing a resume command. After every byte phase the controller keeps SCL low and waits for the next command, so software can pace the transfer at any speed. A single interrupt line pulses each time the controller reaches such a wait point.

The wait point for received bytes can be placed after the eighth clock or after the ninth. With the eighth-clock point, software reads the byte and then chooses whether the master answers with ACK or NACK on the ninth clock. Both bus lines are open-drain: the block only produces pull-low enables and reads the wired levels back. The low and high phases of SCL are each set by a count register, in clock cycles. The same block also watches the bus for start and stop conditions to keep a busy flag and a stop flag.

Register map (byte offsets): data 0x00, control A 0x08, command 0x0C, status 0x10, control B 0x20, low count 0x24, high count 0x28.

Top module: `i2cm_byte_master`

## Requirements
- R1: After reset both pull-low enables are 0, the interrupt is low, and status (0x10) and control A (0x08) read 0.
- R2: A command write with bit 1 set, while control A bit 7 (enable) and control B bit 1 (start output allowed) are both 1, pulls SDA low while SCL is released, then holds SCL low. Status bit 6 (busy) then sets. When control B bit 1 is 0, the same command leaves both lines released.
- R3: A data write (0x00) made while the bus is held shifts out bits [7:0] MSB first, changes SDA only while SCL is low, and releases SDA for a ninth clock. After that clock the interrupt pulses and status bit 8 holds 1 if SDA was low on the ninth clock, 0 if not.
- R4: A command write with bit 2 set (resume), with control A bit 1 at 0, clocks in 8 bits MSB first. The interrupt then pulses after the eighth clock and the byte reads back at 0x00.
- R5: A resume issued at the eighth-clock wait point runs the ninth clock with SDA pulled low if control A bit 0 is 1, and released (NACK) if it is 0. With control A bit 1 at 1 the interrupt comes after that ninth clock.
- R6: After each interrupt point SCL stays pulled low until the next data write or command.
- R7: A command with bit 0 set, issued while the bus is held, pulls SDA low under low SCL, releases SCL and then releases SDA. Status bit 4 (stop seen) then sets and busy clears.
- R8: A start command issued while the bus is held produces a repeated start. SDA is released, then SCL is released, then SDA falls while SCL is high, with no stop in between. Busy stays 1 and the stop flag stays 0.
- R9: The stop flag clears when a new start is generated.
- R10: Writing control A bit 7 to 0 releases both lines, returns the controller to idle and clears all status flags within two cycles.
- R11: The interrupt is high for exactly one clock per wait point.
- R12: Within a byte, every SCL high phase lasts the high count (0x28) in clock cycles and every SCL low phase lasts the low count (0x24).
- R13: Control A bits 7, 1 and 0, control B bits 7 and 1, and the 10-bit count registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Read data, registered one cycle after the address |
| irq | output | 1 | One-cycle pulse at each wait point |
| scl_in | input | 1 | Wired SCL level |
| sda_in | input | 1 | Wired SDA level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bus monitor and the byte sequencer act in the same cycle at a repeated start. The sequencer drives the new start while the monitor must keep busy set and must not report a stop. The bench provokes this by issuing a start command right after an acknowledged byte, and judges it through bench-side counts of start and stop edges on the wired lines together with the status flags. A second overlap arises when a disable lands in the middle of a bit phase while SDA is pulled low. That case is provoked mid-byte and judged on the line enables and the status register.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int unsigned OFS_W = 6;
  localparam logic [OFS_W-1:0] OFS_DATA = 6'h00;
  localparam logic [OFS_W-1:0] OFS_CTLA = 6'h08;
  localparam logic [OFS_W-1:0] OFS_CMD  = 6'h0C;
  localparam logic [OFS_W-1:0] OFS_STAT = 6'h10;
  localparam logic [OFS_W-1:0] OFS_CTLB = 6'h20;
  localparam logic [OFS_W-1:0] OFS_LOW  = 6'h24;
  localparam logic [OFS_W-1:0] OFS_HIGH = 6'h28;

  typedef enum logic [3:0] {
    PH_IDLE, PH_STA, PH_HOLD, PH_LOW, PH_HIGH,
    PH_RS1, PH_RS2, PH_SP1, PH_SP2, PH_SP3
  } phase_t;
endpackage

// File: rtl/i2cm_regs.sv
module i2cm_regs import i2cm_pkg::*; #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned BYTE_W = 8,
  parameter logic [CNT_W-1:0] DEF_LO = 10'd8,
  parameter logic [CNT_W-1:0] DEF_HI = 10'd8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              st_ack,
  input  logic              st_busy,
  input  logic              st_stop,
  output logic              en,
  output logic              wait9,
  output logic              ack_en,
  output logic [CNT_W-1:0]  lim_lo,
  output logic [CNT_W-1:0]  lim_hi,
  output logic              go_sta,
  output logic              go_spt,
  output logic              go_rel,
  output logic              go_tx,
  output logic [BYTE_W-1:0] tx_byte
);
  logic fast_q, sta_ok;
  logic hit_cmd;
  logic unused_wbits;

  assign hit_cmd = bus_we && (bus_addr == ADDR_W'(OFS_CMD)) && en;
  assign unused_wbits = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0; wait9 <= 1'b0; ack_en <= 1'b0;
      fast_q <= 1'b0; sta_ok <= 1'b0;
      lim_lo <= DEF_LO; lim_hi <= DEF_HI;
      go_sta <= 1'b0; go_spt <= 1'b0; go_rel <= 1'b0; go_tx <= 1'b0;
      tx_byte <= '0;
    end else begin
      go_sta <= hit_cmd && bus_wdata[1] && sta_ok;
      go_spt <= hit_cmd && bus_wdata[0];
      go_rel <= hit_cmd && bus_wdata[2];
      go_tx  <= bus_we && (bus_addr == ADDR_W'(OFS_DATA)) && en;
      if (bus_we) begin
        case (bus_addr)
          ADDR_W'(OFS_DATA): tx_byte <= bus_wdata[BYTE_W-1:0];
          ADDR_W'(OFS_CTLA): begin
            en <= bus_wdata[7]; wait9 <= bus_wdata[1]; ack_en <= bus_wdata[0];
          end
          ADDR_W'(OFS_CTLB): begin
            fast_q <= bus_wdata[7]; sta_ok <= bus_wdata[1];
          end
          ADDR_W'(OFS_LOW):  lim_lo <= bus_wdata[CNT_W-1:0];
          ADDR_W'(OFS_HIGH): lim_hi <= bus_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      case (bus_addr)
        ADDR_W'(OFS_DATA): bus_rdata[BYTE_W-1:0] <= rx_byte;
        ADDR_W'(OFS_CTLA): bus_rdata[7:0] <= {en, 5'b0, wait9, ack_en};
        ADDR_W'(OFS_STAT): bus_rdata[8:0] <= {st_ack, 1'b0, st_busy, 1'b0, st_stop, 4'b0};
        ADDR_W'(OFS_CTLB): bus_rdata[7:0] <= {fast_q, 5'b0, sta_ok, 1'b0};
        ADDR_W'(OFS_LOW):  bus_rdata[CNT_W-1:0] <= lim_lo;
        ADDR_W'(OFS_HIGH): bus_rdata[CNT_W-1:0] <= lim_hi;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine import i2cm_pkg::*; #(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CNT_W-1:0]  lim_lo,
  input  logic [CNT_W-1:0]  lim_hi,
  input  logic              wait9,
  input  logic              ack_en,
  input  logic              go_sta,
  input  logic              go_spt,
  input  logic              go_rel,
  input  logic              go_tx,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              irq,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              ack_ok,
  output logic              sta_issued,
  output logic              held,
  output logic              in_high
);
  localparam int unsigned BN_W = $clog2(BYTE_W + 1);

  phase_t            ph;
  logic [CNT_W-1:0]  cnt, lo_eff, hi_eff, cur_lim;
  logic [BN_W-1:0]   bitn;
  logic [BYTE_W-1:0] shreg;
  logic              is_rx, mid, done, hold_pt, last_bit, ack_bit, drive_val;

  assign lo_eff   = (lim_lo == '0) ? CNT_W'(1) : lim_lo;
  assign hi_eff   = (lim_hi == '0) ? CNT_W'(1) : lim_hi;
  assign cur_lim  = (ph == PH_LOW || ph == PH_RS1 || ph == PH_SP1) ? lo_eff : hi_eff;
  assign done     = (cnt >= cur_lim - CNT_W'(1));
  assign hold_pt  = (cnt == (lim_lo >> 2));
  assign last_bit = (bitn == BN_W'(BYTE_W - 1));
  assign ack_bit  = (bitn == BN_W'(BYTE_W));
  assign drive_val = ack_bit ? (is_rx & ack_en) : (~is_rx & ~shreg[BYTE_W-1]);
  assign held     = (ph == PH_HOLD);
  assign in_high  = (ph == PH_HIGH);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ph <= PH_IDLE; cnt <= '0; bitn <= '0; shreg <= '0;
      is_rx <= 1'b0; mid <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
      irq <= 1'b0; rx_byte <= '0; ack_ok <= 1'b0; sta_issued <= 1'b0;
    end else begin
      irq <= 1'b0;
      sta_issued <= 1'b0;
      cnt <= done ? '0 : cnt + CNT_W'(1);
      case (ph)
        PH_IDLE: begin
          cnt <= '0;
          if (go_sta) begin
            ph <= PH_STA; sda_oe <= 1'b1; sta_issued <= 1'b1;
          end
        end
        PH_STA: if (done) begin ph <= PH_HOLD; scl_oe <= 1'b1; end
        PH_HOLD: begin
          cnt <= '0;
          if (go_sta) begin
            ph <= PH_RS1; sda_oe <= 1'b0; sta_issued <= 1'b1; mid <= 1'b0;
          end else if (go_spt) begin
            ph <= PH_SP1; sda_oe <= 1'b1; mid <= 1'b0;
          end else if (go_rel) begin
            ph <= PH_LOW;
            if (mid) mid <= 1'b0;
            else begin is_rx <= 1'b1; bitn <= '0; end
          end else if (go_tx) begin
            ph <= PH_LOW; is_rx <= 1'b0; bitn <= '0; shreg <= tx_byte; mid <= 1'b0;
          end
        end
        PH_LOW: begin
          if (hold_pt) sda_oe <= drive_val;
          if (done) begin ph <= PH_HIGH; scl_oe <= 1'b0; end
        end
        PH_HIGH: if (done) begin
          scl_oe <= 1'b1;
          if (!ack_bit) begin
            shreg <= {shreg[BYTE_W-2:0], is_rx ? sda_in : 1'b0};
            if (last_bit && is_rx) rx_byte <= {shreg[BYTE_W-2:0], sda_in};
            bitn <= bitn + BN_W'(1);
            if (last_bit && is_rx && !wait9) begin
              irq <= 1'b1; mid <= 1'b1; ph <= PH_HOLD;
            end else begin
              ph <= PH_LOW;
            end
          end else begin
            bitn <= '0;
            if (!is_rx) ack_ok <= ~sda_in;
            if (is_rx && !wait9) ph <= PH_LOW;
            else begin irq <= 1'b1; ph <= PH_HOLD; end
          end
        end
        PH_RS1: if (done) begin ph <= PH_RS2; scl_oe <= 1'b0; end
        PH_RS2: if (done) begin ph <= PH_STA; sda_oe <= 1'b1; end
        PH_SP1: if (done) begin ph <= PH_SP2; scl_oe <= 1'b0; end
        PH_SP2: if (done) begin ph <= PH_SP3; sda_oe <= 1'b0; end
        PH_SP3: if (done) ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2cm_busmon.sv
module i2cm_busmon (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic scl_in,
  input  logic sda_in,
  input  logic sta_issued,
  output logic busy,
  output logic stop_seen
);
  logic [1:0] scl_q, sda_q;
  logic start_det, stop_det;

  assign start_det = scl_q[0] & scl_q[1] & sda_q[1] & ~sda_q[0];
  assign stop_det  = scl_q[0] & scl_q[1] & ~sda_q[1] & sda_q[0];

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      scl_q <= 2'b11; sda_q <= 2'b11; busy <= 1'b0; stop_seen <= 1'b0;
    end else begin
      scl_q <= {scl_q[0], scl_in};
      sda_q <= {sda_q[0], sda_in};
      if (start_det) busy <= 1'b1;
      else if (stop_det) busy <= 1'b0;
      if (stop_det) stop_seen <= 1'b1;
      else if (sta_issued) stop_seen <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cm_byte_master.sv
module i2cm_byte_master import i2cm_pkg::*; #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned BYTE_W = 8,
  parameter logic [CNT_W-1:0] DEF_LO = 10'd8,
  parameter logic [CNT_W-1:0] DEF_HI = 10'd8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe
);
  logic en, wait9, ack_en, go_sta, go_spt, go_rel, go_tx;
  logic [CNT_W-1:0]  lim_lo, lim_hi;
  logic [BYTE_W-1:0] tx_byte, rx_byte;
  logic ack_ok, sta_issued, held, in_high, st_busy, st_stop;

  i2cm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W),
              .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_byte(rx_byte),
    .st_ack(ack_ok), .st_busy(st_busy), .st_stop(st_stop),
    .en(en), .wait9(wait9), .ack_en(ack_en), .lim_lo(lim_lo), .lim_hi(lim_hi),
    .go_sta(go_sta), .go_spt(go_spt), .go_rel(go_rel), .go_tx(go_tx),
    .tx_byte(tx_byte));

  i2cm_engine #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_eng (
    .clk(clk), .rst(rst), .en(en), .lim_lo(lim_lo), .lim_hi(lim_hi),
    .wait9(wait9), .ack_en(ack_en), .go_sta(go_sta), .go_spt(go_spt),
    .go_rel(go_rel), .go_tx(go_tx), .tx_byte(tx_byte), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq), .rx_byte(rx_byte),
    .ack_ok(ack_ok), .sta_issued(sta_issued), .held(held), .in_high(in_high));

  i2cm_busmon u_mon (
    .clk(clk), .rst(rst), .en(en), .scl_in(scl_in), .sda_in(sda_in),
    .sta_issued(sta_issued), .busy(st_busy), .stop_seen(st_stop));
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic clk,
  input logic rst,
  input logic en,
  input logic irq,
  input logic scl_oe,
  input logic sda_oe,
  input logic held,
  input logic in_high,
  input logic busy,
  input logic stopf
);
  assert_irq_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  assert_hold_scl_R6: assert property (@(posedge clk) disable iff (rst)
    held |-> scl_oe);

  assert_sda_steady_R3: assert property (@(posedge clk) disable iff (rst)
    (in_high && $past(in_high)) |-> $stable(sda_oe));

  assert_disable_release_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(en) |=> (!scl_oe && !sda_oe && !busy && !stopf));

  assert_busy_stop_R7: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && en) |-> stopf);
endmodule

bind i2cm_byte_master i2cm_checker u_chk (
  .clk(clk), .rst(rst), .en(en), .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .held(held), .in_high(in_high), .busy(st_busy), .stopf(st_stop));

// File: tb/tb_i2cm_byte_master.sv
module tb_i2cm_byte_master;
  logic clk = 1'b0, rst = 1'b1;
  logic bus_we = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic irq, scl_oe, sda_oe, scl_line, sda_line;
  logic slave_pull = 1'b0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;
  assign scl_line = ~scl_oe;
  assign sda_line = ~sda_oe & ~slave_pull;

  i2cm_byte_master dut (.clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .scl_in(scl_line),
    .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe));

  // bench-side slave and line monitor
  logic [17:0] plan = '0, cap = '0;
  int bitidx = 0, rises = 0, starts = 0, stops = 0;
  logic scl_prev = 1'b1, sda_prev = 1'b1;
  always @(negedge clk) begin
    if (scl_prev && !scl_line) begin
      bitidx++;
      slave_pull = (bitidx < 18) ? plan[bitidx] : 1'b0;
    end
    if (!scl_prev && scl_line) begin
      if (bitidx < 18) cap[bitidx] = sda_line;
      rises++;
    end
    if (scl_prev && scl_line && sda_prev && !sda_line) starts++;
    if (scl_prev && scl_line && !sda_prev && sda_line) stops++;
    scl_prev = scl_line;
    sda_prev = sda_line;
  end

  function automatic logic [17:0] rx_plan(input logic [7:0] b, input int off);
    logic [17:0] p = '0;
    for (int k = 0; k < 8; k++) p[off+k] = ~b[7-k];
    return p;
  endfunction

  function automatic logic [7:0] cap_byte(input logic [17:0] c, input int off);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[7-k] = c[off+k];
    return r;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic arm(input logic [17:0] p);
    plan = p; bitidx = 0; rises = 0; cap = '0; slave_pull = p[0];
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(output int pulses);
    int t = 0;
    pulses = 0;
    while (pulses == 0 && t < 4000) begin
      @(negedge clk); t++;
      if (irq) pulses++;
    end
    repeat (6) begin @(negedge clk); if (irq) pulses++; end
  endtask

  task automatic meas(output int hi, output int lo);
    int t = 0;
    hi = 0; lo = 0;
    while (scl_oe && t < 4000) begin @(negedge clk); t++; end
    while (!scl_oe) begin hi++; @(negedge clk); end
    while (scl_oe) begin lo++; @(negedge clk); end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic ack, input string req);
    int p;
    logic [15:0] s;
    arm(ack ? 18'h00100 : 18'h0);
    wr(6'h00, {8'h0, b});
    wait_irq(p);
    chk(p == 1, {req, " one irq pulse R11"}, p, 1);
    chk(rises == 9, {req, " nine clocks R3"}, rises, 9);
    chk(cap_byte(cap, 0) == b, {req, " bits MSB first R3"}, cap_byte(cap, 0), b);
    rd(6'h10, s);
    chk(s[8] == ack, {req, " ack flag R3"}, s[8], ack);
  endtask

  bit fin = 1'b0;
  initial begin
    #(200000 * 10);
    if (!fin) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] s;
    logic [7:0] b, r1, r2;
    int p, hi, lo, st0, sp0;
    void'($urandom(32'd7719));
    idle(10);
    @(negedge clk); rst = 1'b0;
    idle(2);
    // R1 reset state
    chk(!scl_oe && !sda_oe && !irq, "R1 lines and irq", {scl_oe, sda_oe, irq}, 0);
    rd(6'h10, s); chk(s == 0, "R1 status", s, 0);
    rd(6'h08, s); chk(s == 0, "R1 control A", s, 0);
    // R13 readback
    wr(6'h24, 16'd12); wr(6'h28, 16'd10);
    wr(6'h20, 16'h0080); wr(6'h08, 16'h0083);
    rd(6'h08, s); chk(s == 16'h0083, "R13 control A", s, 16'h83);
    rd(6'h20, s); chk(s == 16'h0080, "R13 control B", s, 16'h80);
    rd(6'h24, s); chk(s == 16'd12, "R13 low count", s, 12);
    rd(6'h28, s); chk(s == 16'd10, "R13 high count", s, 10);
    // R2 start blocked without start permission
    arm('0);
    wr(6'h0C, 16'h0002); idle(60);
    chk(!scl_oe && !sda_oe, "R2 start blocked", {scl_oe, sda_oe}, 0);
    rd(6'h10, s); chk(s[6] == 1'b0, "R2 busy stays clear", s[6], 0);
    // R2 start allowed
    wr(6'h20, 16'h0082);
    st0 = starts;
    wr(6'h0C, 16'h0002); idle(40);
    chk(starts == st0 + 1, "R2 start edge", starts, st0 + 1);
    chk(scl_oe == 1'b1, "R6 SCL held after start", scl_oe, 1);
    rd(6'h10, s); chk(s[6] == 1'b1, "R2 busy set", s[6], 1);
    // R3 directed bytes, acked and not acked
    send_byte(8'hA5, 1'b1, "R3 A5 acked");
    send_byte(8'h3C, 1'b0, "R3 3C nack");
    // R6 hold after interrupt point
    p = rises; idle(80);
    chk(scl_oe == 1'b1 && rises == p, "R6 SCL held", rises, p);
    // R12 phase widths
    arm(18'h00100);
    wr(6'h00, 16'h00F0);
    meas(hi, lo);
    chk(hi == 10, "R12 high width", hi, 10);
    chk(lo == 12, "R12 low width", lo, 12);
    wait_irq(p);
    // R8 repeated start
    st0 = starts; sp0 = stops;
    arm('0);
    wr(6'h0C, 16'h0002); idle(80);
    chk(starts == st0 + 1, "R8 repeated start edge", starts, st0 + 1);
    chk(stops == sp0, "R8 no stop", stops, sp0);
    rd(6'h10, s); chk(s[6] == 1'b1 && s[4] == 1'b0, "R8 busy kept", s[6:4], 3'b100);
    send_byte(8'h91, 1'b1, "R8 address after repeat");
    // R4 receive with eighth-clock wait point
    r1 = 8'($urandom); r2 = 8'($urandom);
    wr(6'h08, 16'h0081);
    arm(rx_plan(r1, 0));
    wr(6'h0C, 16'h0004);
    wait_irq(p);
    chk(p == 1, "R11 rx irq", p, 1);
    chk(rises == 8, "R4 eight clocks", rises, 8);
    rd(6'h00, s); chk(s[7:0] == r1, "R4 received byte", s[7:0], r1);
    // R5 continue with ACK then next byte
    arm(rx_plan(r2, 1));
    wr(6'h0C, 16'h0004);
    wait_irq(p);
    chk(rises == 9, "R5 ack plus byte clocks", rises, 9);
    chk(cap[0] == 1'b0, "R5 master ACK", cap[0], 0);
    rd(6'h00, s); chk(s[7:0] == r2, "R4 second byte", s[7:0], r2);
    // R5 final NACK with ninth-clock wait point
    wr(6'h08, 16'h0082);
    arm('0);
    wr(6'h0C, 16'h0004);
    wait_irq(p);
    chk(p == 1 && rises == 1, "R5 irq after ninth clock", rises, 1);
    chk(cap[0] == 1'b1, "R5 master NACK", cap[0], 1);
    // R7 stop
    sp0 = stops;
    wr(6'h0C, 16'h0001); idle(60);
    chk(stops == sp0 + 1, "R7 stop edge", stops, sp0 + 1);
    chk(!scl_oe && !sda_oe, "R7 lines released", {scl_oe, sda_oe}, 0);
    rd(6'h10, s); chk(s[6] == 1'b0 && s[4] == 1'b1, "R7 flags", s[6:4], 3'b001);
    // R9 new start clears stop flag
    wr(6'h0C, 16'h0002); idle(40);
    rd(6'h10, s); chk(s[4] == 1'b0 && s[6] == 1'b1, "R9 stop flag cleared", s[6:4], 3'b100);
    // R10 disable mid-byte
    wr(6'h08, 16'h0083);
    arm('0);
    wr(6'h00, 16'h0000); idle(30);
    wr(6'h08, 16'h0000); idle(3);
    chk(!scl_oe && !sda_oe, "R10 lines released", {scl_oe, sda_oe}, 0);
    rd(6'h10, s); chk(s == 0, "R10 status cleared", s, 0);
    // random widths and bytes
    wr(6'h08, 16'h0083);
    arm('0);
    wr(6'h0C, 16'h0002); idle(60);
    for (int i = 0; i < 5; i++) begin
      int wl, wh;
      wl = 4 + int'($urandom % 12); wh = 4 + int'($urandom % 12);
      b = 8'($urandom);
      wr(6'h24, 16'(wl)); wr(6'h28, 16'(wh));
      arm(18'h00100);
      wr(6'h00, {8'h0, b});
      meas(hi, lo);
      chk(hi == wh, "R12 random high", hi, wh);
      chk(lo == wl, "R12 random low", lo, wl);
      wait_irq(p);
      chk(cap_byte(cap, 0) == b, "R3 random byte", cap_byte(cap, 0), b);
    end
    wr(6'h0C, 16'h0001); idle(80);
    fin = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule